// File: doc/BRIEF.md
# Sized-Access Byte Lane Decoder with Fixed Address Map

This block sits between a processor's load/store path and three byte-wide or word-wide targets in a 24-bit address space. It accepts one access of byte, word or long size and breaks it into single-target transfers. Each transfer goes to one of three targets: a boot ROM, a RAM of configurable installed size, or an external device port. Multi-byte values are big-endian: the most significant byte sits at the lowest address. Read data is assembled in that order, and write data is split in that order.

The map has three fixed features. The first bytes of ROM also appear at address zero, so the start-up vectors can be fetched there. Writes aimed at ROM are dropped without any signal. A RAM read above the installed size returns all-ones. The device port takes a word as one wide transfer, so it does not need byte steering. A sequencer issues one transfer per cycle, then raises `done` for one cycle together with the assembled result.

Top module: `bytelane_mmap`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done` and `addr_err` are low, `rdata` is zero and no strobe is active.
- R2: A read at an address below VEC_SPAN (8) is served by the ROM at offset equal to the address, using `rom_rd` and `rom_addr`.
- R3: Addresses from VEC_SPAN up to ROM_BASE-1 (0x7DFFFF) go to RAM one byte per cycle, with `ram_addr` equal to the byte address. Reads use `ram_rd` and writes use `ram_wr`. At most one strobe of the whole block is active in any cycle.
- R4: A read from ROM_BASE (0x7E0000) up to DEV_BASE-1 (0x7FFFFF) is served by the ROM at offset address minus ROM_BASE.
- R5: Addresses at or above DEV_BASE (0x800000) go to the device port. A byte access is one narrow transfer (`dev_wide`=0, data in bits 7:0). A word access is one wide transfer (`dev_wide`=1). A long access is two wide transfers, at a and then at a+2.
- R6: A write that falls in either ROM window raises no strobe at all. The access still completes with `done`, and later reads return the unchanged ROM content.
- R7: A RAM-window read at or above RAM_BYTES returns 0xFF for each such byte and raises no strobe. A write there is dropped.
- R8: `req_size` selects the access size: 0 is byte, 1 is word, 2 or 3 is long. Read results are big-endian. A word is the byte at a shifted left by 8, ORed with the byte at a+1. A long is the word at a in bits 31:16 and the word at a+2 in bits 15:0. Write data is split in the same order, and a write leaves `rdata` zero.
- R9: A word or long request at an odd address performs no transfer. `done` and `addr_err` are high together on the cycle after the accepting edge, and `rdata` is zero.
- R10: For an aligned request needing N transfers, the transfers occupy the N cycles after the accepting edge. `done` is high for exactly one cycle, N edges after acceptance, with the result on `rdata`. `busy` is then low on the following cycle.
- R11: `start` is only accepted while `busy` is low. A `start` pulse during an access changes neither its transfers nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 long |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write value, right-aligned |
| busy | output | 1 | Access in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| addr_err | output | 1 | Misaligned request, valid with done |
| rdata | output | 32 | Assembled read value, right-aligned |
| rom_rd | output | 1 | ROM byte read strobe |
| rom_addr | output | ROM_AW | ROM byte offset |
| rom_rdata | input | 8 | ROM byte, same-cycle response |
| ram_rd | output | 1 | RAM byte read strobe |
| ram_wr | output | 1 | RAM byte write strobe |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM byte, same-cycle response |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wide | output | 1 | 1 = 16-bit transfer, 0 = byte |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | 16 | Device write data (byte in bits 7:0) |
| dev_rdata | input | 16 | Device read data, same-cycle response |

## Verification
Call the edge that samples `start` edge zero. The transfers of an aligned request show their strobes in the cycles between edges zero and N. `done` follows N edges after edge zero, and a misaligned request gets its `done` one edge after edge zero. The bench drives and samples only on falling edges. For each access it counts falling edges from acceptance and requires `done` to be low on every earlier one and high on exactly the predicted one, where it also checks `addr_err` and `rdata`. The bench also compares every active strobe, with its address, width and data, in the cycle it appears, against a queue of transfers predicted from the address map.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   typedef enum logic [1:0] {
      RG_ROM = 2'd0,
      RG_RAM = 2'd1,
      RG_DEV = 2'd2
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } state_e;

   localparam int unsigned MMAP_DW = 32;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
   import mmap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned VEC_SPAN  = 8,
   parameter int unsigned ROM_BASE  = 24'h7E0000,
   parameter int unsigned DEV_BASE  = 24'h800000,
   parameter int unsigned RAM_BYTES = 65536,
   parameter int unsigned ROM_AW    = 17
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [ROM_AW-1:0] rom_off,
   output logic              ram_present
);

   localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(VEC_SPAN);
   localparam logic [ADDR_W-1:0] ROM_A = ADDR_W'(ROM_BASE);
   localparam logic [ADDR_W-1:0] DEV_A = ADDR_W'(DEV_BASE);
   localparam bit RAM_FILLS_WINDOW = (RAM_BYTES >= ROM_BASE);

   always_comb begin
      region  = RG_RAM;
      rom_off = '0;
      if (addr >= DEV_A) begin
         region = RG_DEV;
      end else if (addr >= ROM_A) begin
         region  = RG_ROM;
         rom_off = ROM_AW'(addr - ROM_A);
      end else if (addr < VEC_A) begin
         region  = RG_ROM;
         rom_off = ROM_AW'(addr);
      end
   end

   generate
      if (RAM_FILLS_WINDOW) begin : g_ram_full
         assign ram_present = 1'b1;
      end else begin : g_ram_partial
         localparam logic [ADDR_W-1:0] RAM_LIM = ADDR_W'(RAM_BYTES);
         assign ram_present = (addr < RAM_LIM);
      end
   endgenerate

endmodule

// File: rtl/mmap_lane_buf.sv
module mmap_lane_buf
   import mmap_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [1:0]         load_size,
   input  logic [MMAP_DW-1:0] wdata,
   input  logic               step,
   input  logic               capture,
   input  logic               wide,
   input  logic [7:0]         in_byte,
   input  logic [15:0]        in_word,
   output logic [7:0]         out_byte,
   output logic [15:0]        out_word,
   output logic [MMAP_DW-1:0] rdata
);

   logic [MMAP_DW-1:0] wbuf_q;
   logic [MMAP_DW-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wbuf_q <= '0;
         acc_q  <= '0;
      end else if (load) begin
         acc_q <= '0;
         case (load_size)
            2'd0:    wbuf_q <= {wdata[7:0], 24'h000000};
            2'd1:    wbuf_q <= {wdata[15:0], 16'h0000};
            default: wbuf_q <= wdata;
         endcase
      end else if (step) begin
         if (wide) begin
            wbuf_q <= {wbuf_q[15:0], 16'h0000};
            if (capture) acc_q <= {acc_q[15:0], in_word};
         end else begin
            wbuf_q <= {wbuf_q[23:0], 8'h00};
            if (capture) acc_q <= {acc_q[23:0], in_byte};
         end
      end
   end

   assign out_byte = wbuf_q[31:24];
   assign out_word = wbuf_q[31:16];
   assign rdata    = acc_q;

endmodule

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
   import mmap_pkg::*;
#(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              unit_wide,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              wr_q,
   output logic              multi_q,
   output logic              step,
   output logic              load,
   output logic              done,
   output logic              addr_err,
   output logic              busy
);

   state_e     state_q;
   logic [2:0] left_q;
   logic       err_q;
   logic [2:0] unit;

   assign unit     = unit_wide ? 3'd2 : 3'd1;
   assign load     = (state_q == ST_IDLE) && start;
   assign step     = (state_q == ST_XFER);
   assign done     = (state_q == ST_DONE);
   assign addr_err = done && err_q;
   assign busy     = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cur_addr <= '0;
         left_q   <= '0;
         wr_q     <= 1'b0;
         multi_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  wr_q     <= req_write;
                  multi_q  <= (req_size != 2'd0);
                  cur_addr <= req_addr;
                  left_q   <= size_bytes(req_size);
                  if ((req_size != 2'd0) && req_addr[0]) begin
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     err_q   <= 1'b0;
                     state_q <= ST_XFER;
                  end
               end
            end
            ST_XFER: begin
               cur_addr <= cur_addr + ADDR_W'(unit);
               left_q   <= left_q - unit;
               if (left_q <= unit) state_q <= ST_DONE;
            end
            ST_DONE: begin
               err_q   <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_len_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (left_q != 3'd0));

   assert_err_no_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && req_size != 2'd0 && req_addr[0]) |=> !step);

endmodule

// File: rtl/bytelane_mmap.sv
module bytelane_mmap
   import mmap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned VEC_SPAN  = 8,
   parameter int unsigned ROM_BASE  = 24'h7E0000,
   parameter int unsigned DEV_BASE  = 24'h800000,
   parameter int unsigned RAM_BYTES = 65536,
   parameter int unsigned ROM_AW    = $clog2(DEV_BASE - ROM_BASE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   output logic               busy,
   output logic               done,
   output logic               addr_err,
   output logic [31:0]        rdata,
   output logic               rom_rd,
   output logic [ROM_AW-1:0]  rom_addr,
   input  logic [7:0]         rom_rdata,
   output logic               ram_rd,
   output logic               ram_wr,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic [7:0]         ram_wdata,
   input  logic [7:0]         ram_rdata,
   output logic               dev_rd,
   output logic               dev_wr,
   output logic               dev_wide,
   output logic [ADDR_W-1:0]  dev_addr,
   output logic [15:0]        dev_wdata,
   input  logic [15:0]        dev_rdata
);

   generate
      if (!(VEC_SPAN > 0 && VEC_SPAN < ROM_BASE && ROM_BASE < DEV_BASE)) begin : g_bad_map
         $error("bytelane_mmap: windows must satisfy 0 < VEC_SPAN < ROM_BASE < DEV_BASE");
      end
      if (DEV_BASE >= (64'd1 << ADDR_W)) begin : g_bad_dev
         $error("bytelane_mmap: DEV_BASE outside the address space");
      end
      if ((64'd1 << ROM_AW) < (DEV_BASE - ROM_BASE) || (64'd1 << ROM_AW) < VEC_SPAN) begin : g_bad_romaw
         $error("bytelane_mmap: ROM_AW too narrow for the ROM windows");
      end
      if (RAM_BYTES == 0 || (DEV_BASE[0] != 1'b0)) begin : g_bad_misc
         $error("bytelane_mmap: RAM_BYTES must be nonzero and DEV_BASE even");
      end
   endgenerate

   logic [ADDR_W-1:0] cur_addr;
   logic              wr_q, multi_q, step, load;
   region_e           region;
   logic [ROM_AW-1:0] rom_off;
   logic              ram_present;
   logic              unit_wide;
   logic [7:0]        in_byte;
   logic [7:0]        out_byte;
   logic [15:0]       out_word;

   mmap_region_decode #(
      .ADDR_W(ADDR_W), .VEC_SPAN(VEC_SPAN), .ROM_BASE(ROM_BASE),
      .DEV_BASE(DEV_BASE), .RAM_BYTES(RAM_BYTES), .ROM_AW(ROM_AW)
   ) u_dec (
      .addr(cur_addr), .region(region), .rom_off(rom_off), .ram_present(ram_present)
   );

   mmap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .unit_wide(unit_wide),
      .cur_addr(cur_addr), .wr_q(wr_q), .multi_q(multi_q), .step(step),
      .load(load), .done(done), .addr_err(addr_err), .busy(busy)
   );

   assign unit_wide = multi_q && (region == RG_DEV);

   always_comb begin
      case (region)
         RG_ROM:  in_byte = rom_rdata;
         RG_RAM:  in_byte = ram_present ? ram_rdata : 8'hFF;
         default: in_byte = dev_rdata[7:0];
      endcase
   end

   mmap_lane_buf u_lanes (
      .clk(clk), .rst_n(rst_n), .load(load), .load_size(req_size),
      .wdata(req_wdata), .step(step), .capture(step && !wr_q),
      .wide(unit_wide), .in_byte(in_byte), .in_word(dev_rdata),
      .out_byte(out_byte), .out_word(out_word), .rdata(rdata)
   );

   assign rom_rd    = step && !wr_q && (region == RG_ROM);
   assign rom_addr  = rom_off;
   assign ram_rd    = step && !wr_q && (region == RG_RAM) && ram_present;
   assign ram_wr    = step &&  wr_q && (region == RG_RAM) && ram_present;
   assign ram_addr  = cur_addr;
   assign ram_wdata = out_byte;
   assign dev_rd    = step && !wr_q && (region == RG_DEV);
   assign dev_wr    = step &&  wr_q && (region == RG_DEV);
   assign dev_wide  = unit_wide;
   assign dev_addr  = cur_addr;
   assign dev_wdata = unit_wide ? out_word : {8'h00, out_byte};

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> done);

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_rd, ram_rd, ram_wr, dev_rd, dev_wr}));

   assert_ram_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd || ram_wr) |-> (ram_addr < ADDR_W'(RAM_BYTES)
                              && ram_addr >= ADDR_W'(VEC_SPAN)
                              && ram_addr < ADDR_W'(ROM_BASE)));

   assert_dev_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd || dev_wr) |-> (dev_addr >= ADDR_W'(DEV_BASE)));

   assert_strobe_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd || ram_rd || ram_wr || dev_rd || dev_wr) |-> (busy && !done));

endmodule

// File: tb/bytelane_mmap_test.sv
`timescale 1ns/1ps
module bytelane_mmap_test;

   localparam int RAM_SZ  = 4096;
   localparam int ROM_B   = 'h7E0000;
   localparam int DEV_B   = 'h800000;
   localparam int VEC     = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, addr_err;
   logic [31:0] rdata;
   logic        rom_rd, ram_rd, ram_wr, dev_rd, dev_wr, dev_wide;
   logic [16:0] rom_addr;
   logic [7:0]  rom_rdata, ram_wdata, ram_rdata;
   logic [23:0] ram_addr, dev_addr;
   logic [15:0] dev_wdata, dev_rdata;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   bytelane_mmap #(.RAM_BYTES(RAM_SZ)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .addr_err(addr_err), .rdata(rdata),
      .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wide(dev_wide),
      .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   function automatic logic [7:0] rom_byte(input int off);
      return 8'((off * 37 + 11) & 'hFF);
   endfunction

   function automatic logic [15:0] dev_word(input int a);
      return 16'(((a * 13) ^ 'h5A3C) & 'hFFFF);
   endfunction

   // behavioural targets
   logic [7:0] ram_mem [0:RAM_SZ-1];
   logic [7:0] mdl_ram [0:RAM_SZ-1];
   initial for (int i = 0; i < RAM_SZ; i++) begin ram_mem[i] = 8'h00; mdl_ram[i] = 8'h00; end

   assign rom_rdata = rom_byte(int'(rom_addr));
   assign ram_rdata = ram_mem[ram_addr[11:0]];
   assign dev_rdata = dev_word(int'(dev_addr));
   always @(posedge clk) if (ram_wr) ram_mem[ram_addr[11:0]] <= ram_wdata;

   // expected transfers: kind 0 rom_rd, 1 ram_rd, 2 ram_wr, 3 dev_rd, 4 dev_wr
   typedef struct { int kind; int addr; int wide; int data; string tag; } xfer_t;
   xfer_t exp_q[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // per-cycle strobe comparison
   always @(negedge clk) begin
      int n;
      int kind;
      int a;
      int d;
      n = int'(rom_rd) + int'(ram_rd) + int'(ram_wr) + int'(dev_rd) + int'(dev_wr);
      if (n > 1) check(0, "R3", "strobes at once", n, 1);
      else if (n == 1) begin
         kind = rom_rd ? 0 : ram_rd ? 1 : ram_wr ? 2 : dev_rd ? 3 : 4;
         a = (kind == 0) ? int'(rom_addr) : (kind <= 2) ? int'(ram_addr) : int'(dev_addr);
         d = (kind == 2) ? int'(ram_wdata) : (kind == 4) ? int'(dev_wdata) : -1;
         if (exp_q.size() == 0) check(0, "R6", "unexpected strobe kind", kind, -1);
         else begin
            xfer_t e;
            e = exp_q.pop_front();
            check(kind == e.kind, e.tag, "strobe kind", kind, e.kind);
            check(a == e.addr, e.tag, "transfer addr", a, e.addr);
            if (kind >= 3) check(int'(dev_wide) == e.wide, e.tag, "dev_wide", dev_wide, e.wide);
            if (e.data >= 0) check(d == e.data, e.tag, "write data", d, e.data);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic push(input int k, input int a, input int w, input int d, input string tag);
      xfer_t e;
      e.kind = k; e.addr = a; e.wide = w; e.data = d; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // one access: model, drive, time-check
   task automatic access(input bit wr, input logic [1:0] sz, input int addr,
                         input logic [31:0] wd, input string tag, input bit poke);
      int nbytes, n, i, a;
      bit err;
      logic [31:0] acc, exp_r;
      logic [7:0] v;
      nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      err = (sz != 0) && addr[0];
      n = 0; acc = '0;
      if (!err) begin
         i = 0;
         while (i < nbytes) begin
            a = addr + i;
            if (a >= DEV_B && sz != 0) begin
               if (wr) push(4, a, 1, int'((wd >> (8 * (nbytes - 2 - i))) & 32'hFFFF), tag);
               else begin push(3, a, 1, -1, tag); acc = (acc << 16) | 32'(dev_word(a)); end
               i += 2;
            end else begin
               logic [7:0] b;
               b = 8'((wd >> (8 * (nbytes - 1 - i))) & 32'hFF);
               v = 8'h00;
               if (a < VEC) begin
                  if (!wr) begin push(0, a, 0, -1, tag); v = rom_byte(a); end
               end else if (a < ROM_B) begin
                  if (a < RAM_SZ) begin
                     if (wr) begin push(2, a, 0, int'(b), tag); mdl_ram[a] = b; end
                     else begin push(1, a, 0, -1, tag); v = mdl_ram[a]; end
                  end else v = 8'hFF;
               end else if (a < DEV_B) begin
                  if (!wr) begin push(0, a - ROM_B, 0, -1, tag); v = rom_byte(a - ROM_B); end
               end else begin
                  if (wr) push(4, a, 0, int'(b), tag);
                  else begin push(3, a, 0, -1, tag); v = dev_word(a)[7:0]; end
               end
               acc = (acc << 8) | 32'(v);
               i += 1;
            end
            n++;
         end
      end
      exp_r = (wr || err) ? 32'h0 : acc;

      @(negedge clk);
      start = 1'b1; req_write = wr; req_size = sz; req_addr = 24'(addr); req_wdata = wd;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c <= n; c++) begin
         if (c > 0) @(negedge clk);
         if (poke && c == 0) begin
            start = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 24'h000010;
            req_wdata = 32'hEE;
         end
         if (poke && c == 1) start = 1'b0;
         check(busy == 1'b1, "R10", "busy during access", busy, 1);
         check(done == (c == n), (c == n) ? tag : "R10", "done timing", done, (c == n));
         if (c == n) begin
            check(addr_err == err, err ? "R9" : tag, "addr_err", addr_err, err);
            check(rdata == exp_r, tag, "rdata", rdata, exp_r);
         end
      end
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R10", "done one cycle then idle",
            {done, busy}, 0);
      check(exp_q.size() == 0, tag, "missing transfers", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !addr_err && rdata == 0, "R1", "outputs in reset",
            {busy, done, addr_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !addr_err && rdata == 0, "R1", "outputs after reset",
            {busy, done, addr_err}, 0);
      check(!(rom_rd || ram_rd || ram_wr || dev_rd || dev_wr), "R1", "no strobe", 1, 0);

      // R2 vector mirror
      access(0, 2'd1, 0, 0, "R2", 0);
      access(0, 2'd2, 4, 0, "R2", 0);
      access(0, 2'd0, 7, 0, "R2", 0);
      // R3 RAM byte path
      access(1, 2'd0, 'h100, 32'hAB, "R3", 0);
      access(0, 2'd0, 'h100, 0, "R3", 0);
      access(0, 2'd0, 8, 0, "R3", 0);
      // R8 big-endian
      access(1, 2'd2, 'h200, 32'h11223344, "R8", 0);
      access(0, 2'd2, 'h200, 0, "R8", 0);
      access(0, 2'd1, 'h202, 0, "R8", 0);
      access(0, 2'd0, 'h201, 0, "R8", 0);
      access(1, 2'd1, 'h300, 32'hFFFFA55A, "R8", 0);
      access(0, 2'd3, 'h2FE, 0, "R8", 0);
      // R4 upper ROM window
      access(0, 2'd2, 'h7E0010, 0, "R4", 0);
      access(0, 2'd0, 'h7FFFFF, 0, "R4", 0);
      // R6 ROM writes dropped
      access(1, 2'd1, 'h7E0020, 32'h1234, "R6", 0);
      access(1, 2'd0, 4, 32'h99, "R6", 0);
      access(0, 2'd1, 'h7E0020, 0, "R6", 0);
      access(0, 2'd0, 4, 0, "R6", 0);
      // R7 beyond installed RAM
      access(0, 2'd2, 'h2000, 0, "R7", 0);
      access(1, 2'd0, RAM_SZ, 32'h77, "R7", 0);
      access(0, 2'd1, RAM_SZ - 1 - 1, 0, "R7", 0);
      access(0, 2'd1, RAM_SZ - 1 + 1, 0, "R7", 0);
      // R5 device port
      access(0, 2'd0, 'h800001, 0, "R5", 0);
      access(1, 2'd0, 'h800003, 32'h5C, "R5", 0);
      access(1, 2'd1, 'h800010, 32'hBEEF, "R5", 0);
      access(0, 2'd2, 'h900000, 0, "R5", 0);
      access(1, 2'd2, 'hA00004, 32'hCAFEF00D, "R5", 0);
      access(0, 2'd2, 'h7FFFFE, 0, "R5", 0);
      // R9 misaligned
      access(0, 2'd1, 'h201, 0, "R9", 0);
      access(1, 2'd2, 'h800003, 32'h1, "R9", 0);
      // R11 start while busy
      access(0, 2'd2, 'h200, 0, "R11", 1);
      access(0, 2'd0, 'h10, 0, "R11", 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule